// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page-to-frame mappings and sits ahead of the page-table walker. Each lookup presents a virtual address. The page-number field is compared against every stored tag at the same time. On a match, the physical address is formed in the same cycle by joining the stored frame number with the untouched page offset.

The walker is started in parallel with the compare, not after it. Every lookup raises a walk start, and a same-cycle cancel withdraws it when the compare hits. When the walker answers with a refill, the mapping is installed. It goes into the lowest free slot if one exists, and otherwise over the slot named by a round-robin pointer. A refill that arrives together with a lookup of the same page is forwarded straight to that lookup. A flush empties the whole table at once. Two counters tally hits and misses so that traffic totals can be checked.

Top module: `tlb_top`

## Requirements
- R1: All valid tags are compared in parallel and at most one slot matches. On a hit, `lk_hit` is high in the lookup cycle and `lk_paddr` equals {frame[19:0], vaddr[11:0]}. The page number is vaddr[31:12].
- R2: `walk_start` is high in every cycle that `lk_valid` is high. `walk_cancel` is high in exactly those cycles where that lookup hits.
- R3: A lookup whose page is neither stored nor being refilled in that cycle gives `lk_hit`=0 and `walk_cancel`=0, with `walk_vpn` equal to the page number.
- R4: A refill (`fill_valid`) stores its page and frame at the clock edge. A lookup of that page in any later cycle hits with the new frame.
- R5: While any slot is free, a refill of a page not yet stored goes into the lowest-numbered free slot.
- R6: When all 8 slots are valid, a refill of a new page replaces the slot named by a pointer. The pointer resets to 0 and steps by one (wrapping 7 to 0) on every refill that installs a new page. A flush does not move it.
- R7: A refill of a page already stored overwrites that slot's frame in place. No other entry is lost and the pointer does not move.
- R8: When `fill_valid` is high and `fill_vpn` equals the looked-up page in the same cycle, the lookup hits with `fill_pfn` as its frame, even if an older mapping of the page is stored.
- R9: `flush` invalidates every slot at the clock edge. A lookup in the flush cycle still sees the old contents. A refill presented in the flush cycle is discarded.
- R10: `hit_count` increments by one for each lookup that hits, including forwarded ones. `miss_count` increments by one for each lookup that misses. Neither counter changes in other cycles, and flush leaves both unchanged.
- R11: After reset all slots are invalid and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_paddr | output | 32 | Translated address, valid when lk_hit |
| walk_start | output | 1 | Page-table walk launched alongside the compare |
| walk_cancel | output | 1 | Abort of the walk launched this cycle |
| walk_vpn | output | 20 | Page number sent to the walker |
| fill_valid | input | 1 | Refill mapping presented by the walker |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| hit_count | output | 16 | Running count of hits |
| miss_count | output | 16 | Running count of misses |

## Verification
The assertions take for granted that the walker never presents a refill for a page that another slot already holds under a different index. The block guarantees this itself through the in-place rewrite, so the one-match property depends only on refills carrying a 20-bit page with no X bits. The assertions also assume that the counters do not wrap during a run. The stimulus keeps to these assumptions: each refill drives fully known values, and the run is far shorter than 65536 lookups. Every mapping's expected frame is derived arithmetically from its page number, and a lookup sweep over all pages ever installed is repeated after each phase.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 20;
    localparam int OFF_W   = 12;
    localparam int ENTRIES = 8;
    localparam int CNT_W   = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int VA_W    = VPN_W + OFF_W;
    localparam int PA_W    = PFN_W + OFF_W;

    typedef logic [ENTRIES-1:0] slot_vec_t;
    typedef logic [IDX_W-1:0]   slot_idx_t;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;

    typedef struct packed {
        logic             hit;
        logic [PFN_W-1:0] pfn;
    } xlate_t;

    function automatic slot_idx_t lowest_set(slot_vec_t v);
        slot_idx_t r = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (v[i]) r = slot_idx_t'(i);
        return r;
    endfunction

    function automatic slot_idx_t onehot_idx(slot_vec_t v);
        slot_idx_t r = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (v[i]) r = r | slot_idx_t'(i);
        return r;
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             fill_we,
    input  slot_idx_t        fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    output slot_vec_t        look_match,
    output slot_vec_t        fill_match,
    output slot_vec_t        valid_vec,
    output logic [PFN_W-1:0] look_pfn
);
    tlb_entry_t ent [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ent[i].valid <= 1'b0;
            end else if (fill_we && fill_idx == slot_idx_t'(i)) begin
                ent[i] <= '{valid: 1'b1, tag: fill_vpn, pfn: fill_pfn};
            end
        end
        assign valid_vec[i]  = ent[i].valid;
        assign look_match[i] = ent[i].valid && (ent[i].tag == look_vpn);
        assign fill_match[i] = ent[i].valid && (ent[i].tag == fill_vpn);
    end

    always_comb begin
        look_pfn = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (look_match[i]) look_pfn = look_pfn | ent[i].pfn;
    end

    // R1
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_match));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R4
    fill_installs_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_we && !flush) |=> valid_vec[$past(fill_idx)]);
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl
    import tlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_vec_t valid_vec,
    input  logic      alloc,
    output slot_idx_t victim
);
    slot_idx_t ptr;
    logic      full;

    assign full   = &valid_vec;
    assign victim = full ? ptr : lowest_set(~valid_vec);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (alloc)
            ptr <= (ptr == slot_idx_t'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end

    // R5
    free_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc && !full) |-> !valid_vec[victim]);
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             walk_start,
    output logic             walk_cancel,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    slot_vec_t        look_match, fill_match, valid_vec;
    logic [PFN_W-1:0] cam_pfn;
    slot_idx_t        victim, fill_idx;
    logic             fill_we, in_place, alloc, fwd;
    xlate_t           res;

    assign vpn = lk_vaddr[VA_W-1:OFF_W];
    assign off = lk_vaddr[OFF_W-1:0];

    tlb_cam u_cam (
        .clk(clk), .rst(rst), .flush(flush),
        .look_vpn(vpn),
        .fill_we(fill_we), .fill_idx(fill_idx),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .look_match(look_match), .fill_match(fill_match),
        .valid_vec(valid_vec), .look_pfn(cam_pfn)
    );

    tlb_repl u_repl (
        .clk(clk), .rst(rst),
        .valid_vec(valid_vec), .alloc(alloc), .victim(victim)
    );

    // Install path
    assign in_place = |fill_match;
    assign fill_we  = fill_valid && !flush;
    assign alloc    = fill_we && !in_place;
    assign fill_idx = in_place ? onehot_idx(fill_match) : victim;

    // Lookup path: a same-cycle refill wins over a stored entry
    assign fwd = fill_valid && (fill_vpn == vpn);
    always_comb begin
        res.hit = lk_valid && (fwd || (|look_match));
        res.pfn = fwd ? fill_pfn : cam_pfn;
    end

    assign lk_hit      = res.hit;
    assign lk_paddr    = {res.pfn, off};
    assign walk_start  = lk_valid;
    assign walk_cancel = res.hit;
    assign walk_vpn    = vpn;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (lk_valid) begin
            if (res.hit) hit_count  <= hit_count + 1'b1;
            else         miss_count <= miss_count + 1'b1;
        end
    end

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R2
    cancel_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        walk_cancel |-> walk_start);

    // R10
    hit_tally_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |=> (hit_count == $past(hit_count) + 1'b1)
                                  && $stable(miss_count));

    // R10
    miss_tally_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |=> (miss_count == $past(miss_count) + 1'b1)
                                   && $stable(hit_count));

    // R10
    idle_tally_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> $stable(hit_count) && $stable(miss_count));
endmodule

// File: tb/tlb_top_tb.sv
module tlb_top_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst, flush, lk_valid, fill_valid;
    logic [31:0] lk_vaddr;
    logic [19:0] fill_vpn, fill_pfn;
    logic        lk_hit, walk_start, walk_cancel;
    logic [31:0] lk_paddr;
    logic [19:0] walk_vpn;
    logic [15:0] hit_count, miss_count;

    always #10 clk = ~clk;

    tlb_top u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .walk_start(walk_start), .walk_cancel(walk_cancel), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0;
    int errors = 0;

    // Reference model of the table contents
    logic        m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_pfn   [N];
    int          m_ptr;
    int          exp_hits, exp_misses;

    // Pages ever installed, used for sweeps
    logic [19:0] known [64];
    int          n_known = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] frame_of(input logic [19:0] v, input int gen);
        return (v ^ 20'hA5A5A) + 20'(gen * 20'h101);
    endfunction

    task automatic add_known(input logic [19:0] v);
        for (int i = 0; i < n_known; i++)
            if (known[i] == v) return;
        known[n_known] = v;
        n_known++;
    endtask

    // One cycle: drive at negedge, check combinational outputs, commit at posedge
    task automatic step(input logic lv, input logic [31:0] va,
                        input logic fv, input logic [19:0] fvpn, input logic [19:0] fpfn,
                        input logic fl);
        logic        found, fwd, e_hit, in_pl;
        logic [19:0] e_pfn;
        int          slot, fi;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; flush = fl;
        #2;
        found = 1'b0; e_pfn = '0;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == va[31:12]) begin found = 1'b1; e_pfn = m_pfn[i]; end
        fwd   = fv && (fvpn == va[31:12]);
        if (fwd) e_pfn = fpfn;
        e_hit = lv && (found || fwd);
        if (lv) begin
            check(fwd ? "R8 hit" : (e_hit ? "R1 hit" : "R3 miss"), lk_hit, e_hit);
            if (e_hit) check(fwd ? "R8 paddr" : "R1 paddr", lk_paddr, {e_pfn, va[11:0]});
            check("R2 walk_start", walk_start, 1'b1);
            check("R2 walk_cancel", walk_cancel, e_hit);
            if (!e_hit) check("R3 walk_vpn", walk_vpn, va[31:12]);
            if (e_hit) exp_hits++; else exp_misses++;
        end else begin
            check("R2 idle", {walk_start, walk_cancel}, 2'b00);
        end
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end else if (fv) begin
            in_pl = 1'b0; slot = 0;
            for (int i = 0; i < N; i++)
                if (m_valid[i] && m_vpn[i] == fvpn) begin in_pl = 1'b1; slot = i; end
            if (!in_pl) begin
                fi = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) fi = i;
                slot = (fi >= 0) ? fi : m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_valid[slot] = 1'b1; m_vpn[slot] = fvpn; m_pfn[slot] = fpfn;
            add_known(fvpn);
        end
        #1;
        check("R10 hit_count", hit_count, 16'(exp_hits));
        check("R10 miss_count", miss_count, 16'(exp_misses));
    endtask

    task automatic fill(input logic [19:0] v, input int gen);
        step(1'b0, '0, 1'b1, v, frame_of(v, gen), 1'b0);
    endtask

    task automatic sweep(input int salt);
        for (int i = 0; i < n_known; i++) begin
            logic [11:0] o = 12'((i * 12'h155 + salt * 12'h3E7) & 12'hFFF);
            if (i == 0) o = 12'h000;
            if (i == 1) o = 12'hFFF;
            step(1'b1, {known[i], o}, 1'b0, '0, '0, 1'b0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; end
        m_ptr = 0; exp_hits = 0; exp_misses = 0;
        rst = 1'b1; flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R11: counters zero and every page misses after reset
        check("R11 hit_count", hit_count, 16'd0);
        check("R11 miss_count", miss_count, 16'd0);
        for (int i = 0; i < N; i++) step(1'b1, {20'h00100 + 20'(i), 12'h abc}, 1'b0, '0, '0, 1'b0);

        // R4, R5: fill an empty table, then every page hits
        for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 0);
        sweep(1);

        // R6: full table, pointer at 0 evicts the first installed page
        fill(20'h00200, 0);
        sweep(2);
        check("R6 evicted", m_valid[0] && m_vpn[0] == 20'h00200, 1'b1);
        fill(20'h00201, 0);
        sweep(3);

        // R7: rewrite of a stored page in place, pointer unchanged
        fill(20'h00105, 1);
        sweep(4);
        fill(20'h00202, 0);
        sweep(5);

        // R8: refill forwarded to a lookup of the same page
        step(1'b1, {20'h00300, 12'h123}, 1'b1, 20'h00300, frame_of(20'h00300, 0), 1'b0);
        step(1'b1, {20'h00300, 12'h456}, 1'b0, '0, '0, 1'b0);
        // R8: forwarded frame beats the stored one
        step(1'b1, {20'h00106, 12'h010}, 1'b1, 20'h00106, frame_of(20'h00106, 2), 1'b0);
        sweep(6);

        // R9: lookup in the flush cycle sees old contents; refill with flush dropped
        step(1'b1, {20'h00107, 12'h777}, 1'b0, '0, '0, 1'b1);
        step(1'b1, {20'h00107, 12'h777}, 1'b1, 20'h00400, frame_of(20'h00400, 0), 1'b1);
        step(1'b1, {20'h00400, 12'h001}, 1'b0, '0, '0, 1'b0);
        sweep(7);

        // R5, R6 after flush: lowest free slots, then pointer continues
        for (int i = 0; i < N + 3; i++) begin
            fill(20'h00500 + 20'(i * 7), 3);
            sweep(8 + i);
        end

        // R2: idle cycles raise no walk signals, counters hold
        repeat (3) step(1'b0, '0, 1'b0, '0, '0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule